// File: doc/BRIEF.md
# Event Timer Global Section

This block is the shared part of a high-precision event timer. It owns a free-running up-counter that advances by one on every cycle in which the single-cycle tick input is high, as long as the global enable is set. It also holds a global configuration word, a fixed capability word and a sticky interrupt-pending word. The block sends the counter value and the enable and routing-mode flags to the comparator channels, and it takes their pending strobes back in.

Software reaches the registers through a plain 64-bit port. The byte address selects a 64-bit word. Writes take effect on the clock edge where the write strobe is high. Reads are combinational from the address. The counter can be preset only while it is halted. Pending bits are cleared by writing ones. A pending bit reaches the interrupt output only while the global enable is set.

Top module: `evt_timer_global`

## Requirements
- R1: After reset the configuration word, the pending word and the counter are all 0, and `enable_o`, `legacy_o` and `irq_o` are 0.
- R2: A read at offset 0x000 returns the capability word. Bits 63:32 hold the tick period in femtoseconds and bits 7:0 hold the revision. Bits 12:8 hold the timer count minus one, bit 13 is 1 when the counter is 64 bits wide, and bit 15 reports legacy-routing support. All other bits read 0, and writes to this word have no effect.
- R3: At offset 0x010, bit 0 (global enable) and bit 1 (legacy routing) are writable, and bits 63:2 always read 0. `enable_o` follows bit 0 and `legacy_o` follows bit 1.
- R4: While the enable is 1, the counter increases by exactly 1 on each clock edge where `tick_i` is 1. It holds its value when `tick_i` is 0 or the enable is 0.
- R5: A write at offset 0x0F0 loads the counter with the written value only while the enable is 0. While the enable is 1, such a write is ignored.
- R6: When `tmr_pend_i[n]` is 1 at a clock edge, bit n of the pending word (offset 0x020) reads 1 from the next cycle on. The bit stays set until it is cleared.
- R7: A write at offset 0x020 clears each pending bit whose written bit is 1. Written 0 bits have no effect. If a pending strobe arrives at the same edge as the clear, the set wins.
- R8: `irq_o[n]` is 1 only while pending bit n is 1 and the enable is 1.
- R9: With a 32-bit counter, reads at 0x0F0 return 0 in bits 63:32, a load keeps only the low 32 bits, and the counter wraps from all ones to 0.
- R10: Reads at unmapped offsets return 0, and writes there change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Single-cycle counter tick enable |
| addr_i | input | 12 | Register byte offset |
| wr_en_i | input | 1 | Write strobe |
| wdata_i | input | 64 | Write data |
| rdata_o | output | 64 | Read data, combinational from `addr_i` |
| tmr_pend_i | input | NUM_TIMERS | Per-timer pending strobes from the comparators |
| count_o | output | CNT_W | Counter value sent to the comparators |
| enable_o | output | 1 | Global enable |
| legacy_o | output | 1 | Legacy routing mode |
| irq_o | output | NUM_TIMERS | Gated interrupt per timer |

## Verification
The bench builds the block with a 32-bit counter, four timers, a 20 ns tick period and legacy support. These settings make the zeroed upper read half and the all-ones-to-zero wrap reachable within a few cycles. They also make the capability word carry a nonzero timer count and a set legacy bit. With four pending bits, the bench can test partial clears, ignored zero writes and a set colliding with a clear on separate bits.

// File: rtl/evt_timer_pkg.sv
package evt_timer_pkg;
  localparam int unsigned REG_AW = 12;

  localparam logic [REG_AW-1:0] OFF_CAP = 12'h000;
  localparam logic [REG_AW-1:0] OFF_CFG = 12'h010;
  localparam logic [REG_AW-1:0] OFF_STS = 12'h020;
  localparam logic [REG_AW-1:0] OFF_CNT = 12'h0F0;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_CAP, SEL_CFG, SEL_STS, SEL_CNT
  } reg_sel_e;

  function automatic reg_sel_e decode(input logic [REG_AW-1:0] a);
    unique case (a[REG_AW-1:3])
      OFF_CAP[REG_AW-1:3]: decode = SEL_CAP;
      OFF_CFG[REG_AW-1:3]: decode = SEL_CFG;
      OFF_STS[REG_AW-1:3]: decode = SEL_STS;
      OFF_CNT[REG_AW-1:3]: decode = SEL_CNT;
      default:             decode = SEL_NONE;
    endcase
  endfunction
endpackage

// File: rtl/evt_main_counter.sv
module evt_main_counter #(
  parameter int unsigned CNT_W = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             tick_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic [CNT_W-1:0] count_o
);
  logic [CNT_W-1:0] count_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                count_q <= '0;
    else if (load_i && !run_i)  count_q <= load_val_i;
    else if (run_i && tick_i)   count_q <= count_q + 1'b1;
  end

  assign count_o = count_q;
endmodule

// File: rtl/evt_int_status.sv
module evt_int_status #(
  parameter int unsigned NUM_TIMERS = 3
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [NUM_TIMERS-1:0] pend_i,
  input  logic                  clr_i,
  input  logic [NUM_TIMERS-1:0] clr_mask_i,
  output logic [NUM_TIMERS-1:0] status_o
);
  logic [NUM_TIMERS-1:0] sts_q;
  logic [NUM_TIMERS-1:0] clr_vec;

  assign clr_vec = clr_i ? clr_mask_i : '0;

  // set has priority over a same-edge clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sts_q <= '0;
    else         sts_q <= (sts_q & ~clr_vec) | pend_i;
  end

  assign status_o = sts_q;
endmodule

// File: rtl/evt_reg_read.sv
module evt_reg_read
  import evt_timer_pkg::*;
#(
  parameter int unsigned NUM_TIMERS = 3,
  parameter int unsigned CNT_W      = 64
) (
  input  logic [REG_AW-1:0]     addr_i,
  input  logic [63:0]           cap_i,
  input  logic [1:0]            cfg_i,
  input  logic [NUM_TIMERS-1:0] status_i,
  input  logic [CNT_W-1:0]      count_i,
  output logic [63:0]           rdata_o
);
  always_comb begin
    unique case (decode(addr_i))
      SEL_CAP: rdata_o = cap_i;
      SEL_CFG: rdata_o = {62'd0, cfg_i};
      SEL_STS: rdata_o = 64'(status_i);
      SEL_CNT: rdata_o = 64'(count_i);
      default: rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/evt_timer_global.sv
module evt_timer_global
  import evt_timer_pkg::*;
#(
  parameter int unsigned NUM_TIMERS = 3,
  parameter int unsigned CNT_W      = 64,
  parameter logic [31:0] TICK_FS    = 32'd10_000_000,
  parameter logic [7:0]  REV_ID     = 8'h01,
  parameter bit          LEGACY_CAP = 1'b1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  tick_i,
  input  logic [11:0]           addr_i,
  input  logic                  wr_en_i,
  input  logic [63:0]           wdata_i,
  output logic [63:0]           rdata_o,
  input  logic [NUM_TIMERS-1:0] tmr_pend_i,
  output logic [CNT_W-1:0]      count_o,
  output logic                  enable_o,
  output logic                  legacy_o,
  output logic [NUM_TIMERS-1:0] irq_o
);
  localparam logic [63:0] CAP_WORD = {TICK_FS, 16'h0000, LEGACY_CAP, 1'b0,
                                      1'(CNT_W == 64), 5'(NUM_TIMERS - 1), REV_ID};

  reg_sel_e              wsel;
  logic [1:0]            cfg_q;
  logic [NUM_TIMERS-1:0] status_q;
  logic                  unused_bits;

  assign wsel        = decode(addr_i);
  assign unused_bits = ^{wdata_i, addr_i[2:0]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          cfg_q <= 2'b00;
    else if (wr_en_i && wsel == SEL_CFG)  cfg_q <= wdata_i[1:0];
  end

  evt_main_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .run_i      (cfg_q[0]),
    .tick_i     (tick_i),
    .load_i     (wr_en_i && wsel == SEL_CNT),
    .load_val_i (wdata_i[CNT_W-1:0]),
    .count_o    (count_o)
  );

  evt_int_status #(.NUM_TIMERS(NUM_TIMERS)) u_sts (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pend_i     (tmr_pend_i),
    .clr_i      (wr_en_i && wsel == SEL_STS),
    .clr_mask_i (wdata_i[NUM_TIMERS-1:0]),
    .status_o   (status_q)
  );

  evt_reg_read #(.NUM_TIMERS(NUM_TIMERS), .CNT_W(CNT_W)) u_rd (
    .addr_i   (addr_i),
    .cap_i    (CAP_WORD),
    .cfg_i    (cfg_q),
    .status_i (status_q),
    .count_i  (count_o),
    .rdata_o  (rdata_o)
  );

  assign enable_o = cfg_q[0];
  assign legacy_o = cfg_q[1];
  assign irq_o    = status_q & {NUM_TIMERS{cfg_q[0]}};
endmodule

// File: rtl/evt_timer_global_chk.sv
module evt_timer_global_chk #(
  parameter int unsigned NUM_TIMERS = 3,
  parameter int unsigned CNT_W      = 64
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  tick_i,
  input logic [11:0]           addr_i,
  input logic                  wr_en_i,
  input logic [63:0]           wdata_i,
  input logic [NUM_TIMERS-1:0] tmr_pend_i,
  input logic [CNT_W-1:0]      count_o,
  input logic                  enable_o,
  input logic [NUM_TIMERS-1:0] irq_o,
  input logic [NUM_TIMERS-1:0] status_q
);
  logic cnt_wr, sts_wr;
  assign cnt_wr = wr_en_i && addr_i[11:3] == 9'h01E;
  assign sts_wr = wr_en_i && addr_i[11:3] == 9'h004;

  // R4
  count_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!enable_o && !cnt_wr) |=> $stable(count_o));

  // R4
  count_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enable_o && tick_i) |=> count_o == CNT_W'($past(count_o) + 1'b1));

  // R5
  count_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!enable_o && cnt_wr) |=> count_o == $past(wdata_i[CNT_W-1:0]));

  // R6
  pend_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|tmr_pend_i) |=> (status_q & $past(tmr_pend_i)) == $past(tmr_pend_i));

  // R7
  sts_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sts_wr |=> (status_q & $past(status_q)) == $past(status_q));

  // R8
  irq_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_o |-> irq_o == '0);
endmodule

bind evt_timer_global evt_timer_global_chk #(.NUM_TIMERS(NUM_TIMERS), .CNT_W(CNT_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .addr_i(addr_i), .wr_en_i(wr_en_i),
  .wdata_i(wdata_i), .tmr_pend_i(tmr_pend_i), .count_o(count_o), .enable_o(enable_o),
  .irq_o(irq_o), .status_q(status_q)
);

// File: tb/evt_timer_global_bench.sv
module evt_timer_global_bench;
  localparam int unsigned NT    = 4;
  localparam int unsigned CW    = 32;
  localparam logic [31:0] TFS   = 32'd20_000_000;
  localparam logic [7:0]  REV   = 8'h02;
  localparam logic [63:0] CAP_EXP = {TFS, 16'h0, 1'b1, 1'b0, 1'b0, 5'(NT - 1), REV};
  localparam logic [11:0] A_CAP = 12'h000, A_CFG = 12'h010, A_STS = 12'h020, A_CNT = 12'h0F0;

  typedef struct packed {
    logic        rd;
    logic [11:0] addr;
    logic [63:0] data;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VEC [NV] = '{
    '{1'b1, A_CAP,  CAP_EXP,               8'd2},
    '{1'b0, A_CAP,  64'hFFFF_FFFF_FFFF_FFFF, 8'd2},
    '{1'b1, A_CAP,  CAP_EXP,               8'd2},
    '{1'b0, A_CFG,  64'hFFFF_FFFF_FFFF_FFFF, 8'd3},
    '{1'b1, A_CFG,  64'h3,                 8'd3},
    '{1'b0, A_CFG,  64'h0,                 8'd3},
    '{1'b0, A_CNT,  64'h1234_5678_9ABC_DEF0, 8'd9},
    '{1'b1, A_CNT,  64'h0000_0000_9ABC_DEF0, 8'd9},
    '{1'b0, A_CFG,  64'h1,                 8'd5},
    '{1'b0, A_CNT,  64'h55,                8'd5},
    '{1'b1, A_CNT,  64'h0000_0000_9ABC_DEF0, 8'd5},
    '{1'b0, A_CFG,  64'h0,                 8'd5},
    '{1'b0, 12'h040, 64'hFFFF_FFFF_FFFF_FFFF, 8'd10},
    '{1'b1, 12'h040, 64'h0,                8'd10},
    '{1'b1, 12'h018, 64'h0,                8'd10},
    '{1'b0, A_CNT,  64'h55,                8'd5},
    '{1'b1, A_CNT,  64'h55,                8'd5}
  };

  logic          clk_i = 1'b0, rst_ni = 1'b0, tick_i = 1'b0, wr_en_i = 1'b0;
  logic [11:0]   addr_i = '0;
  logic [63:0]   wdata_i = '0, rdata_o;
  logic [NT-1:0] tmr_pend_i = '0, irq_o;
  logic [CW-1:0] count_o;
  logic          enable_o, legacy_o;
  int            n_chk = 0, n_bad = 0;
  bit            done = 1'b0;

  always #10 clk_i = ~clk_i;

  evt_timer_global #(.NUM_TIMERS(NT), .CNT_W(CW), .TICK_FS(TFS), .REV_ID(REV),
                     .LEGACY_CAP(1'b1)) u_evt_timer_global (.*);

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [63:0] d);
    @(negedge clk_i); addr_i = a; wdata_i = d; wr_en_i = 1'b1;
    @(negedge clk_i); wr_en_i = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [63:0] d);
    @(negedge clk_i); addr_i = a; #1 d = rdata_o;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i); tick_i = 1'b1;
      @(negedge clk_i); tick_i = 1'b0;
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : main
    logic [63:0] v;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // R1 reset state
    rd(A_CFG, v); check("R1 cfg", v, 64'h0);
    rd(A_STS, v); check("R1 sts", v, 64'h0);
    rd(A_CNT, v); check("R1 cnt", v, 64'h0);
    check("R1 outs", {61'd0, enable_o, legacy_o, |irq_o}, 64'h0);

    // R2 R3 R5 R9 R10 vector table
    for (int k = 0; k < NV; k++) begin
      if (VEC[k].rd) begin
        rd(VEC[k].addr, v);
        check($sformatf("R%0d vec%0d", VEC[k].req, k), v, VEC[k].data);
      end else begin
        wr(VEC[k].addr, VEC[k].data);
      end
    end

    // R3 legacy flag routing
    wr(A_CFG, 64'h2);
    check("R3 legacy_o", {62'd0, legacy_o, enable_o}, 64'h2);

    // R4 counting, gated by tick and enable
    wr(A_CNT, 64'd100);
    wr(A_CFG, 64'h1);
    ticks(5);
    repeat (4) @(negedge clk_i);
    rd(A_CNT, v); check("R4 count 5 ticks", v, 64'd105);
    wr(A_CFG, 64'h0);
    ticks(3);
    rd(A_CNT, v); check("R4 halted hold", v, 64'd105);

    // R9 wrap
    wr(A_CNT, 64'hFFFF_FFFF);
    wr(A_CFG, 64'h1);
    ticks(1);
    rd(A_CNT, v); check("R9 wrap", v, 64'h0);
    wr(A_CFG, 64'h0);

    // R6 R8 pending and gating
    @(negedge clk_i); tmr_pend_i = 4'b0100;
    @(negedge clk_i); tmr_pend_i = 4'b0000;
    repeat (2) @(negedge clk_i);
    rd(A_STS, v); check("R6 sticky set", v, 64'h4);
    check("R8 irq gated off", 64'(irq_o), 64'h0);
    wr(A_CFG, 64'h1);
    check("R8 irq delivered", 64'(irq_o), 64'h4);

    // R7 write-one-to-clear
    wr(A_STS, 64'h0);
    rd(A_STS, v); check("R7 zero write", v, 64'h4);
    wr(A_STS, 64'h1);
    rd(A_STS, v); check("R7 other bit", v, 64'h4);
    wr(A_STS, 64'h4);
    rd(A_STS, v); check("R7 clear", v, 64'h0);
    @(negedge clk_i); tmr_pend_i = 4'b0010; addr_i = A_STS; wdata_i = 64'h2; wr_en_i = 1'b1;
    @(negedge clk_i); tmr_pend_i = 4'b0000; wr_en_i = 1'b0;
    rd(A_STS, v); check("R7 set wins", v, 64'h2);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule